// File: doc/BRIEF.md
# Privileged-Mode Trap and Interrupt Dispatcher

This block decides, once per clock, whether the processor must enter its privileged firmware mode. It weighs a synchronous exception request against four pending interrupt lines. The interrupt lines are device, timer, inter-processor and machine check. The current interrupt priority level (IPL) masks some of them, and the firmware-mode flag blocks all of them.

When a request is accepted, the block computes the entry vector as an offset from the firmware base register. It then loads the new program counter, records the return address with the mode flag packed into bit 0, forces the mode flag to 1 and pulses a taken strobe. The surrounding pipeline feeds the returned values back into its own state. It also drops a request once that request has been taken.

Unknown exception kinds are refused and flagged. Return from firmware mode is handled elsewhere.

Top module: `pal_dispatch`

## Requirements
- R1: While reset is asserted and after its release, with no request pending, newPc, excAddr, errCode, palModeOut, taken and badCode are all 0.
- R2: excKind selects a fixed vector for codes 0 to 9: 0 reset 0x000, 1 machine check 0x080, 2 inter-processor 0x100, 3 timer 0x180, 4 device 0x200, 5 memory fault 0x280, 6 unaligned 0x300, 7 illegal opcode 0x380, 8 arithmetic 0x400, 9 FP disabled 0x480. On acceptance, newPc = palBase + vector, truncated to AW bits.
- R3: excKind 10 is a firmware call. If excCode bit 7 is set, newPc = palBase + 0x2000 + excCode[6:0]*64. Otherwise newPc = palBase + 0x1000 + excCode*64. Both results are truncated to AW bits.
- R4: On an accepted exception, excAddr = curPc with bit 0 ORed with palModeIn, palModeOut = 1 and errCode = excCode. Exceptions are accepted whatever the value of palModeIn.
- R5: Results are registered. Outputs change on the clock edge that ends the request cycle, and taken is high for exactly that one following cycle. With no accepted request, newPc, excAddr, errCode and palModeOut hold their values and taken is 0.
- R6: No interrupt is accepted while palModeIn is 1.
- R7: IPL masks interrupts by level. IPL 0 to 3 allows all four sources, IPL 4 masks device, IPL 5 also masks timer, IPL 6 allows only machine check, and IPL 7 allows none.
- R8: Among eligible interrupts, the order is machine check, then inter-processor, then timer, then device. An accepted interrupt uses the vector of its kind from R2 and sets errCode to 0.
- R9: An exception request with a known kind wins over any pending interrupt in the same cycle.
- R10: An exception request with excKind 11 to 15 changes none of newPc, excAddr, errCode or palModeOut. It accepts no interrupt in that cycle, and it gives a one-cycle badCode pulse on the following cycle with taken 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqDev | input | 1 | Device interrupt pending |
| irqClk | input | 1 | Timer interrupt pending |
| irqIpi | input | 1 | Inter-processor interrupt pending |
| irqMchk | input | 1 | Machine check pending |
| ipl | input | 3 | Current interrupt priority level |
| palModeIn | input | 1 | Current firmware-mode flag |
| excReq | input | 1 | Synchronous exception request |
| excKind | input | 4 | Exception kind code (R2, R3) |
| excCode | input | 8 | Call number / error code of the exception |
| curPc | input | AW | Program counter at the request |
| palBase | input | AW | Firmware base address |
| newPc | output | AW | Entry address after dispatch |
| excAddr | output | AW | Saved return address, bit 0 = prior mode |
| palModeOut | output | 1 | Firmware-mode flag after dispatch |
| errCode | output | 8 | Error code latched on entry |
| taken | output | 1 | One-cycle dispatch strobe |
| badCode | output | 1 | One-cycle pulse for an unknown exception kind |

## Verification
The bench builds the block with AW set to 16 rather than the default 32. At that width, a high firmware base plus a large call vector carries out of the address, so the truncation stated in R3 can be observed directly on newPc. Every IPL value from 0 to 7 is paired with the source sitting exactly at its masking boundary. Exceptions are mixed with pending interrupts to expose the precedence order.

// File: rtl/pal_disp_pkg.sv
package pal_disp_pkg;
  localparam int KIND_W  = 4;
  localparam int CODE_W  = 8;
  localparam int OFF_W   = 14;
  localparam int NUM_IRQ = 4;
  localparam int IPL_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    K_RESET   = 4'd0,
    K_MCHK    = 4'd1,
    K_IPI     = 4'd2,
    K_TIMER   = 4'd3,
    K_DEVICE  = 4'd4,
    K_MEMFLT  = 4'd5,
    K_UNALIGN = 4'd6,
    K_OPCODE  = 4'd7,
    K_ARITH   = 4'd8,
    K_FPOFF   = 4'd9,
    K_CALL    = 4'd10
  } vecKind_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic                load;
    logic                fromIrq;
    logic                badReq;
    logic [KIND_W-1:0]   kind;
  } dispCtl_t;
endpackage

// File: rtl/pal_disp_ctrl.sv
module pal_disp_ctrl
  import pal_disp_pkg::*;
(
  input  logic [NUM_IRQ-1:0] irqLines,   // 0 device, 1 timer, 2 ipi, 3 mchk
  input  logic [IPL_W-1:0]   ipl,
  input  logic               palModeIn,
  input  logic               excReq,
  input  logic [KIND_W-1:0]  excKind,
  output dispCtl_t           ctl
);
  logic [NUM_IRQ-1:0] eligible;
  logic [KIND_W-1:0]  irqKind;
  logic               anyIrq;

  // source i stays eligible while ipl is below 4+i
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
    localparam logic [IPL_W:0] LIMIT = (IPL_W+1)'(4 + i);
    assign eligible[i] = irqLines[i] & ({1'b0, ipl} < LIMIT) & ~palModeIn;
  end

  // higher index wins; kind is 4 - index
  always_comb begin
    irqKind = K_DEVICE;
    anyIrq  = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i]) begin
        irqKind = KIND_W'(4 - i);
        anyIrq  = 1'b1;
      end
    end
  end

  always_comb begin
    ctl = '0;
    if (excReq) begin
      if (excKind <= K_CALL) begin
        ctl.load = 1'b1;
        ctl.kind = excKind;
      end else begin
        ctl.badReq = 1'b1;
      end
    end else if (anyIrq) begin
      ctl.load    = 1'b1;
      ctl.fromIrq = 1'b1;
      ctl.kind    = irqKind;
    end
  end
endmodule

// File: rtl/pal_disp_dpath.sv
module pal_disp_dpath
  import pal_disp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dispCtl_t          ctl,
  input  logic [CODE_W-1:0] excCode,
  input  logic [AW-1:0]     curPc,
  input  logic [AW-1:0]     palBase,
  input  logic              palModeIn,
  output logic [AW-1:0]     newPc,
  output logic [AW-1:0]     excAddr,
  output logic              palModeOut,
  output logic [CODE_W-1:0] errCode,
  output logic              taken,
  output logic              badCode
);
  localparam logic [OFF_W-1:0] CALL_PRIV = OFF_W'(14'h1000);
  localparam logic [OFF_W-1:0] CALL_USER = OFF_W'(14'h2000);

  logic [OFF_W-1:0] offset;
  logic [AW-1:0]    target;

  always_comb begin
    if (ctl.kind == K_CALL)
      offset = (excCode[CODE_W-1] ? CALL_USER : CALL_PRIV)
             + {1'b0, excCode[CODE_W-2:0], 6'b0};
    else
      offset = {3'b0, ctl.kind, 7'b0};
    target = palBase + AW'(offset);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc      <= '0;
      excAddr    <= '0;
      palModeOut <= 1'b0;
      errCode    <= '0;
      taken      <= 1'b0;
      badCode    <= 1'b0;
    end else begin
      taken   <= ctl.load;
      badCode <= ctl.badReq;
      if (ctl.load) begin
        newPc      <= target;
        excAddr    <= {curPc[AW-1:1], curPc[0] | palModeIn};
        palModeOut <= 1'b1;
        errCode    <= ctl.fromIrq ? '0 : excCode;
      end
    end
  end
endmodule

// File: rtl/pal_dispatch.sv
module pal_dispatch
  import pal_disp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqDev,
  input  logic              irqClk,
  input  logic              irqIpi,
  input  logic              irqMchk,
  input  logic [2:0]        ipl,
  input  logic              palModeIn,
  input  logic              excReq,
  input  logic [3:0]        excKind,
  input  logic [7:0]        excCode,
  input  logic [AW-1:0]     curPc,
  input  logic [AW-1:0]     palBase,
  output logic [AW-1:0]     newPc,
  output logic [AW-1:0]     excAddr,
  output logic              palModeOut,
  output logic [7:0]        errCode,
  output logic              taken,
  output logic              badCode
);
  dispCtl_t ctl;

  pal_disp_ctrl u_ctrl (
    .irqLines  ({irqMchk, irqIpi, irqClk, irqDev}),
    .ipl       (ipl),
    .palModeIn (palModeIn),
    .excReq    (excReq),
    .excKind   (excKind),
    .ctl       (ctl)
  );

  pal_disp_dpath #(.AW(AW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .excCode    (excCode),
    .curPc      (curPc),
    .palBase    (palBase),
    .palModeIn  (palModeIn),
    .newPc      (newPc),
    .excAddr    (excAddr),
    .palModeOut (palModeOut),
    .errCode    (errCode),
    .taken      (taken),
    .badCode    (badCode)
  );
endmodule

// File: rtl/pal_dispatch_chk.sv
module pal_dispatch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqDev,
  input logic          irqClk,
  input logic          irqIpi,
  input logic          irqMchk,
  input logic [2:0]    ipl,
  input logic          palModeIn,
  input logic          excReq,
  input logic [3:0]    excKind,
  input logic [AW-1:0] curPc,
  input logic [AW-1:0] newPc,
  input logic [AW-1:0] excAddr,
  input logic          palModeOut,
  input logic          taken,
  input logic          badCode
);
  AST_PAL_SET: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> palModeOut);  // R4
  AST_PAL_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && palModeIn) |=> !taken);  // R6
  AST_IPL7_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && ipl == 3'd7) |=> !taken);  // R7
  AST_SAVE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> excAddr == ($past(curPc) | AW'($past(palModeIn))));  // R4
  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excKind <= 4'd10) |=> taken);  // R9
  AST_BAD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    badCode |-> (!taken && $stable(newPc) && $stable(excAddr)));  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !taken |-> $stable(newPc));  // R5
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({taken, badCode}));  // R10
endmodule

bind pal_dispatch pal_dispatch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .irqDev(irqDev), .irqClk(irqClk), .irqIpi(irqIpi),
  .irqMchk(irqMchk), .ipl(ipl), .palModeIn(palModeIn), .excReq(excReq),
  .excKind(excKind), .curPc(curPc), .newPc(newPc), .excAddr(excAddr),
  .palModeOut(palModeOut), .taken(taken), .badCode(badCode)
);

// File: tb/pal_dispatch_test.sv
module pal_dispatch_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqDev = 0, irqClk = 0, irqIpi = 0, irqMchk = 0;
  logic [2:0] ipl = '0;
  logic palModeIn = 0, excReq = 0;
  logic [3:0] excKind = '0;
  logic [7:0] excCode = '0;
  logic [AW-1:0] curPc = '0, palBase = '0;
  logic [AW-1:0] newPc, excAddr;
  logic palModeOut, taken, badCode;
  logic [7:0] errCode;

  int total = 0, bad = 0;
  int cycle = 0;
  bit done = 0;

  typedef struct {
    int            due;
    string         tag;
    logic [AW-1:0] pc, ea;
    logic          pm, tk, bc;
    logic [7:0]    ec;
  } item_t;
  item_t q[$];

  // model state of the outputs
  logic [AW-1:0] mPc = '0, mEa = '0;
  logic          mPm = 0;
  logic [7:0]    mEc = '0;

  pal_dispatch #(.AW(AW)) uut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic int fixedVec(input int k);
    case (k)
      0: return 'h000;  1: return 'h080;  2: return 'h100;  3: return 'h180;
      4: return 'h200;  5: return 'h280;  6: return 'h300;  7: return 'h380;
      8: return 'h400;  default: return 'h480;
    endcase
  endfunction

  task automatic drive(input logic rq, input int kind, input logic [7:0] code,
                       input logic [3:0] irq, input int lvl, input logic pm,
                       input logic [AW-1:0] pc, input logic [AW-1:0] base,
                       input string tag);
    item_t it;
    int vec;
    int pick;
    @(negedge clk);
    excReq = rq; excKind = 4'(kind); excCode = code;
    {irqMchk, irqIpi, irqClk, irqDev} = irq;
    ipl = 3'(lvl); palModeIn = pm; curPc = pc; palBase = base;
    it.tk = 0; it.bc = 0; pick = -1; vec = 0;
    if (rq) begin
      if (kind > 10) it.bc = 1;
      else begin
        it.tk = 1;
        if (kind == 10) vec = code[7] ? ('h2000 + int'(code[6:0]) * 64) : ('h1000 + int'(code) * 64);
        else vec = fixedVec(kind);
        mEc = code;
      end
    end else if (!pm) begin
      if (irq[0] && lvl <= 3) pick = 4;
      if (irq[1] && lvl <= 4) pick = 3;
      if (irq[2] && lvl <= 5) pick = 2;
      if (irq[3] && lvl <= 6) pick = 1;
      if (pick > 0) begin it.tk = 1; vec = fixedVec(pick); mEc = '0; end
    end
    if (it.tk) begin
      mPc = AW'(int'(base) + vec);
      mEa = pc | AW'(pm);
      mPm = 1;
    end
    it.pc = mPc; it.ea = mEa; it.pm = mPm; it.ec = mEc;
    it.due = cycle + 1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 8'h00, 4'b0000, 0, 0, '0, '0, tag);
  endtask

  // monitor: compare each expected item in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cycle) begin
      item_t e;
      e = q.pop_front();
      total++;
      if (newPc !== e.pc || excAddr !== e.ea || palModeOut !== e.pm ||
          errCode !== e.ec || taken !== e.tk || badCode !== e.bc) begin
        bad++;
        $display("FAIL %s: got pc=%h ea=%h pm=%b ec=%h tk=%b bc=%b exp pc=%h ea=%h pm=%b ec=%h tk=%b bc=%b",
                 e.tag, newPc, excAddr, palModeOut, errCode, taken, badCode,
                 e.pc, e.ea, e.pm, e.ec, e.tk, e.bc);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;  // R1 reset state
    if (newPc !== '0 || excAddr !== '0 || palModeOut !== 0 || errCode !== 0 || taken !== 0 || badCode !== 0) begin
      bad++;
      $display("FAIL R1: got pc=%h ea=%h pm=%b tk=%b exp all zero", newPc, excAddr, palModeOut, taken);
    end
    rstN = 1'b1;
    idle("R1 idle after reset");
    drive(1, 0, 8'h11, 4'b0000, 0, 0, 16'h1234, 16'h4000, "R2 reset vector");
    drive(1, 9, 8'h22, 4'b0000, 0, 0, 16'h0010, 16'h8000, "R2 fp-disabled vector");
    drive(1, 5, 8'h33, 4'b0000, 0, 1, 16'h2220, 16'h0100, "R4 mode bit saved");
    drive(1, 10, 8'h83, 4'b0000, 0, 0, 16'h0040, 16'h0000, "R3 user call");
    drive(1, 10, 8'h05, 4'b0000, 0, 0, 16'h0044, 16'h0000, "R3 privileged call");
    drive(1, 10, 8'hFF, 4'b0000, 0, 0, 16'h0048, 16'hF000, "R3 call wraps");
    idle("R5 hold and strobe drop");
    idle("R5 hold again");
    drive(0, 0, 8'h00, 4'b1111, 0, 0, 16'h0500, 16'h6000, "R8 mchk first");
    drive(0, 0, 8'h00, 4'b0011, 3, 0, 16'h0504, 16'h6000, "R8 timer over device");
    drive(0, 0, 8'h00, 4'b0100, 0, 0, 16'h0506, 16'h6000, "R8 ipi alone");
    drive(0, 0, 8'h00, 4'b0001, 4, 0, 16'h0508, 16'h6000, "R7 device masked at 4");
    drive(0, 0, 8'h00, 4'b0010, 4, 0, 16'h050C, 16'h6000, "R7 timer open at 4");
    drive(0, 0, 8'h00, 4'b0010, 5, 0, 16'h0510, 16'h6000, "R7 timer masked at 5");
    drive(0, 0, 8'h00, 4'b0100, 5, 0, 16'h0514, 16'h6000, "R7 ipi open at 5");
    drive(0, 0, 8'h00, 4'b0111, 6, 0, 16'h0518, 16'h6000, "R7 only mchk at 6");
    drive(0, 0, 8'h00, 4'b1000, 6, 0, 16'h051C, 16'h6000, "R7 mchk at 6");
    drive(0, 0, 8'h00, 4'b1111, 7, 0, 16'h0520, 16'h6000, "R7 none at 7");
    drive(0, 0, 8'h00, 4'b1111, 0, 1, 16'h0524, 16'h6000, "R6 blocked in mode");
    drive(1, 7, 8'h44, 4'b1111, 0, 0, 16'h0528, 16'h3000, "R9 exception wins");
    drive(1, 12, 8'h55, 4'b1111, 0, 0, 16'h052C, 16'h3000, "R10 unknown kind");
    drive(1, 15, 8'h66, 4'b0000, 0, 0, 16'h0530, 16'h3000, "R10 unknown kind 15");
    drive(1, 8, 8'h77, 4'b0000, 0, 1, 16'h0534, 16'h3000, "R4 exception in mode");
    idle("R5 final idle");
    idle("R5 drain");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule